// File: doc/BRIEF.md
# Flash Read Window Line Cache

This block presents a serial flash as a read-only memory window, holding one line of `LINE_BYTES` (1024 by default) in a local buffer. A 32-bit read is answered from the buffer when it falls inside the held line. On a miss, the block fetches the whole aligned line through a byte-wide SPI engine and then answers the stalled read. A fetch starts by sending a read header built from the configuration word: the opcode, a 24-bit address, an optional mode byte, and a number of zero filler bytes. Then one zero byte is sent for each data byte collected. The bytes returned while the header is being sent are dropped.

The window spans two flash devices of 16 MB each. Bit 24 of the flash address picks the device, and that choice is shown on an upper-page output for as long as the fetch runs. With the parallel-bus option on, the flash address is half the window address. Writing the configuration word discards the held line. A fetch that such a write overlaps is not kept, so the next read fetches again under the new settings.

Top module: `flash_line_cache`

## Requirements
- R1: After reset, `rd_ready`, `flash_sel` and `spi_tx_valid` are low, and the configuration word is 0x03A002EB. Under it, a fetch header is opcode 0xEB, three address bytes, mode byte 0xA0 and two filler bytes.
- R2: A read that is not a hit is held with `rd_ready` low while the line is fetched. It is then answered exactly once, and `rd_ready` is never high during a fetch. Every fetch begins at an address whose low log2(`LINE_BYTES`) bits are zero.
- R3: The header starts with the opcode from configuration bits 7:0, followed by flash address bits 23:16, 15:8 and 7:0, in that order.
- R4: When configuration bit 25 is 1, a mode byte equal to configuration bits 23:16 comes right after the address. When that bit is 0, no mode byte is sent.
- R5: The header ends with N bytes of 0x00, where N is configuration bits 10:8 (0 to 7).
- R6: A fetch transfers header-length plus `LINE_BYTES` bytes. The bytes returned during the header are discarded, exactly `LINE_BYTES` returned bytes are stored, and every byte sent in the data phase is 0x00.
- R7: A read whose line offset is 0 to `LINE_BYTES`-4 inside the held line is a hit. It is answered with `rd_ready` one cycle after the request, as a single-cycle pulse, and starts no fetch. An offset of `LINE_BYTES`-3 or above always fetches, and the buffer index then wraps within the line.
- R8: `rd_data` is little-endian: bits 7:0 come from the buffer byte at the read offset, and each next byte comes from the following offset.
- R9: Flash address bit 24 selects the upper device. `upper_page` equals that bit while `flash_sel` is high and is 0 otherwise.
- R10: A `cfg_wr` pulse loads `cfg_wdata` and invalidates the line, so the next read fetches again. If the pulse falls during a fetch, that fetch is discarded and repeated with the new word. No read is answered in the cycle after `cfg_wr`.
- R11: With configuration bit 30 set (parallel buses), the flash address is the aligned window address shifted right by one.
- R12: `flash_sel` is high exactly while a fetch runs. `spi_tx_valid` is only raised while `flash_sel` is high, and only one byte is outstanding: the next byte is offered after the previous `spi_rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, held with `rd_addr` until `rd_ready` |
| rd_addr | input | ADDR_W | Byte address in the window |
| rd_data | output | 32 | Little-endian read word, valid with `rd_ready` |
| rd_ready | output | 1 | One-cycle read completion |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | New configuration word |
| spi_tx_valid | output | 1 | Byte offered to the SPI engine |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_tx_ready | input | 1 | SPI engine accepts the offered byte |
| spi_rx_valid | input | 1 | Received byte available |
| spi_rx_byte | input | 8 | Received byte |
| flash_sel | output | 1 | Flash selected, high while a fetch runs |
| upper_page | output | 1 | Upper device selected during a fetch |

## Verification
The assertions check the following on every cycle:
- a completion is a single pulse, follows a request, and never coincides with a running fetch;
- `upper_page` and byte requests stay inside the select window;
- every finished fetch has stored exactly one line of bytes;
- a configuration write blocks a completion on the next cycle.

Only the directed scenarios can show what goes out on the wire and what comes back. This covers the header byte order and its content under several configuration words, the address halving and device selection, the little-endian word at aligned, unaligned and end-of-line offsets, and the refetch that follows a configuration write, including one that lands mid-fetch.

// File: rtl/flc_pkg.sv
package flc_pkg;

  localparam logic [31:0] CFG_RESET   = 32'h03A0_02EB;
  localparam int          MODE_EN_BIT = 25;
  localparam int          DUAL_BIT    = 30;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_SEND,
    FS_WAIT
  } fill_state_t;

  // opcode + 3 address bytes + optional mode byte + filler count
  function automatic logic [4:0] header_len(input logic [31:0] cfg);
    return 5'd4 + {4'd0, cfg[MODE_EN_BIT]} + {2'd0, cfg[10:8]};
  endfunction

  function automatic logic [7:0] header_byte(input logic [31:0] cfg,
                                             input logic [23:0] faddr,
                                             input logic [4:0]  pos);
    logic [7:0] b;
    case (pos)
      5'd0:    b = cfg[7:0];
      5'd1:    b = faddr[23:16];
      5'd2:    b = faddr[15:8];
      5'd3:    b = faddr[7:0];
      5'd4:    b = cfg[MODE_EN_BIT] ? cfg[23:16] : 8'h00;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/flc_hdr_gen.sv
module flc_hdr_gen
  import flc_pkg::*;
(
  input  logic [31:0] cfg,
  input  logic [23:0] faddr,
  input  logic [4:0]  pos,
  output logic [7:0]  hbyte
);

  always_comb hbyte = header_byte(cfg, faddr, pos);

endmodule

// File: rtl/flc_line_buf.sv
module flc_line_buf #(
  parameter int LINE_BYTES = 1024,
  parameter int OFF_W      = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [OFF_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [OFF_W-1:0] roff,
  output logic [31:0]      rword
);

  logic [7:0] mem [LINE_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // four byte lanes, lowest offset in the lowest lane; index wraps in the line
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign rword[8*g +: 8] = mem[roff + OFF_W'(g)];
  end

endmodule

// File: rtl/flc_fill_ctrl.sv
module flc_fill_ctrl
  import flc_pkg::*;
#(
  parameter int LINE_BYTES = 1024,
  parameter int OFF_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      start_cfg,
  input  logic [24:0]      start_faddr,
  output logic             spi_tx_valid,
  output logic [7:0]       spi_tx_byte,
  input  logic             spi_tx_ready,
  input  logic             spi_rx_valid,
  input  logic [7:0]       spi_rx_byte,
  output logic             busy,
  output logic             upper_sel,
  output logic             done,
  output logic             buf_we,
  output logic [OFF_W-1:0] buf_waddr,
  output logic [7:0]       buf_wdata
);

  localparam int IDX_W = $clog2(LINE_BYTES + 16);

  fill_state_t      st;
  logic [IDX_W-1:0] idx;
  logic [4:0]       hlen;
  logic [31:0]      fcfg;
  logic [23:0]      faddr;
  logic             upper;
  logic             in_hdr;
  logic             last;
  logic [7:0]       hbyte;
  logic [IDX_W-1:0] data_idx;

  flc_hdr_gen u_hdr (
    .cfg   (fcfg),
    .faddr (faddr),
    .pos   (idx[4:0]),
    .hbyte (hbyte)
  );

  always_comb begin
    in_hdr       = idx < IDX_W'(hlen);
    last         = idx == (IDX_W'(hlen) + IDX_W'(LINE_BYTES - 1));
    data_idx     = idx - IDX_W'(hlen);
    busy         = st != FS_IDLE;
    upper_sel    = busy && upper;
    spi_tx_valid = st == FS_SEND;
    spi_tx_byte  = in_hdr ? hbyte : 8'h00;
    buf_we       = (st == FS_WAIT) && spi_rx_valid && !in_hdr;
    buf_waddr    = data_idx[OFF_W-1:0];
    buf_wdata    = spi_rx_byte;
    done         = (st == FS_WAIT) && spi_rx_valid && last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= FS_IDLE;
      idx   <= '0;
      hlen  <= '0;
      fcfg  <= '0;
      faddr <= '0;
      upper <= 1'b0;
    end else begin
      case (st)
        FS_IDLE: if (start) begin
          fcfg  <= start_cfg;
          faddr <= start_faddr[23:0];
          upper <= start_faddr[24];
          hlen  <= header_len(start_cfg);
          idx   <= '0;
          st    <= FS_SEND;
        end
        FS_SEND: if (spi_tx_ready) st <= FS_WAIT;
        FS_WAIT: if (spi_rx_valid) begin
          if (last) st <= FS_IDLE;
          else begin
            idx <= idx + 1'b1;
            st  <= FS_SEND;
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_line_cache.sv
module flash_line_cache
  import flc_pkg::*;
#(
  parameter int LINE_BYTES = 1024,
  parameter int ADDR_W     = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_ready,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic              spi_tx_valid,
  output logic [7:0]        spi_tx_byte,
  input  logic              spi_tx_ready,
  input  logic              spi_rx_valid,
  input  logic [7:0]        spi_rx_byte,
  output logic              flash_sel,
  output logic              upper_page
);

  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int TAG_W   = ADDR_W - OFF_W;
  localparam int MAX_OFF = LINE_BYTES - 4;

  function automatic logic in_line(input logic valid, input logic [TAG_W-1:0] held,
                                   input logic [TAG_W-1:0] tag, input logic [OFF_W-1:0] off);
    return valid && (held == tag) && (off <= OFF_W'(MAX_OFF));
  endfunction

  function automatic logic [24:0] to_flash(input logic [31:0] c, input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] s;
    s = c[DUAL_BIT] ? (a >> 1) : a;
    return s[24:0];
  endfunction

  logic [31:0]      cfg_q;
  logic             line_valid;
  logic [TAG_W-1:0] line_tag;
  logic             stale;
  logic             just_filled;
  logic             rd_ready_q;
  logic [31:0]      rd_data_q;

  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] req_off;
  logic             hit;
  logic             serve;
  logic             fill_start;
  logic             fill_busy;
  logic             fill_done;
  logic             upper_sel;
  logic [24:0]      start_faddr;
  logic             buf_we;
  logic [OFF_W-1:0] buf_waddr;
  logic [7:0]       buf_wdata;
  logic [31:0]      buf_word;
  logic             open_req;

  always_comb begin
    req_tag     = rd_addr[ADDR_W-1:OFF_W];
    req_off     = rd_addr[OFF_W-1:0];
    hit         = in_line(line_valid, line_tag, req_tag, req_off);
    open_req    = rd_req && !rd_ready_q && !fill_busy && !cfg_wr;
    serve       = open_req && (hit || just_filled);
    fill_start  = open_req && !hit && !just_filled;
    start_faddr = to_flash(cfg_q, {req_tag, {OFF_W{1'b0}}});
  end

  flc_fill_ctrl #(
    .LINE_BYTES (LINE_BYTES),
    .OFF_W      (OFF_W)
  ) u_fill (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (fill_start),
    .start_cfg    (cfg_q),
    .start_faddr  (start_faddr),
    .spi_tx_valid (spi_tx_valid),
    .spi_tx_byte  (spi_tx_byte),
    .spi_tx_ready (spi_tx_ready),
    .spi_rx_valid (spi_rx_valid),
    .spi_rx_byte  (spi_rx_byte),
    .busy         (fill_busy),
    .upper_sel    (upper_sel),
    .done         (fill_done),
    .buf_we       (buf_we),
    .buf_waddr    (buf_waddr),
    .buf_wdata    (buf_wdata)
  );

  flc_line_buf #(
    .LINE_BYTES (LINE_BYTES),
    .OFF_W      (OFF_W)
  ) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .roff  (req_off),
    .rword (buf_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q       <= CFG_RESET;
      line_valid  <= 1'b0;
      line_tag    <= '0;
      stale       <= 1'b0;
      just_filled <= 1'b0;
      rd_ready_q  <= 1'b0;
      rd_data_q   <= '0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_wdata;
      rd_ready_q  <= serve;
      if (serve) rd_data_q <= buf_word;
      just_filled <= fill_done && !stale && !cfg_wr;
      if (fill_start) begin
        line_valid <= 1'b0;
        line_tag   <= req_tag;
        stale      <= 1'b0;
      end else if (cfg_wr) begin
        line_valid <= 1'b0;
        if (fill_busy) stale <= 1'b1;
      end else if (fill_done && !stale) begin
        line_valid <= 1'b1;
      end
    end
  end

  assign rd_ready   = rd_ready_q;
  assign rd_data    = rd_data_q;
  assign flash_sel  = fill_busy;
  assign upper_page = upper_sel;

endmodule

// File: rtl/flc_checker.sv
module flc_checker #(
  parameter int LINE_BYTES = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic rd_ready,
  input logic cfg_wr,
  input logic flash_sel,
  input logic upper_page,
  input logic spi_tx_valid,
  input logic fill_start,
  input logic fill_done,
  input logic fill_busy,
  input logic buf_we
);

  localparam int CNT_W = $clog2(LINE_BYTES) + 1;

  logic [CNT_W-1:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          wr_cnt <= '0;
    else if (fill_start) wr_cnt <= '0;
    else if (buf_we)     wr_cnt <= wr_cnt + 1'b1;
  end

  assert_ready_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> $past(rd_req));

  assert_no_ready_in_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !rd_ready);

  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);

  assert_upper_in_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upper_page |-> flash_sel);

  assert_tx_while_selected_R12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid |-> flash_sel);

  assert_line_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (wr_cnt == CNT_W'(LINE_BYTES - 1)));

  assert_inval_blocks_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !rd_ready);

endmodule

bind flash_line_cache flc_checker #(.LINE_BYTES(LINE_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req       (rd_req),
  .rd_ready     (rd_ready),
  .cfg_wr       (cfg_wr),
  .flash_sel    (flash_sel),
  .upper_page   (upper_page),
  .spi_tx_valid (spi_tx_valid),
  .fill_start   (fill_start),
  .fill_done    (fill_done),
  .fill_busy    (fill_busy),
  .buf_we       (buf_we)
);

// File: tb/flash_line_cache_test.sv
module flash_line_cache_test;

  localparam int CLK_PERIOD = 10;
  localparam int LB         = 1024;
  localparam int AW         = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic          rd_ready;
  logic          cfg_wr = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          spi_tx_valid;
  logic [7:0]    spi_tx_byte;
  logic          spi_tx_ready = 1'b1;
  logic          spi_rx_valid;
  logic [7:0]    spi_rx_byte;
  logic          flash_sel;
  logic          upper_page;

  int checks = 0;
  int failures = 0;
  logic [31:0] bench_cfg = 32'h03A0_02EB;

  // flash model bookkeeping
  int         fills = 0;
  int         k = 0;
  int         bhdr = 0;
  int         tx_total = 0;
  int         nz_data = 0;
  bit         upper_seen = 0;
  logic       prev_sel = 1'b0;
  logic [7:0] hlog [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_line_cache #(.LINE_BYTES(LB), .ADDR_W(AW)) uut (
    .clk (clk), .rst_n (rst_n), .rd_req (rd_req), .rd_addr (rd_addr),
    .rd_data (rd_data), .rd_ready (rd_ready), .cfg_wr (cfg_wr), .cfg_wdata (cfg_wdata),
    .spi_tx_valid (spi_tx_valid), .spi_tx_byte (spi_tx_byte), .spi_tx_ready (spi_tx_ready),
    .spi_rx_valid (spi_rx_valid), .spi_rx_byte (spi_rx_byte),
    .flash_sel (flash_sel), .upper_page (upper_page)
  );

  function automatic logic [7:0] pat(input logic dev, input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[22:16], dev};
  endfunction

  function automatic int hdr_len_of(input logic [31:0] c);
    return 4 + int'(c[25]) + int'(c[10:8]);
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] c, input logic [AW-1:0] a);
    logic [AW-1:0] base, fa;
    logic [31:0]   w;
    int            off;
    base = a & ~AW'(LB - 1);
    fa   = c[30] ? (base >> 1) : base;
    off  = int'(a[9:0]);
    for (int i = 0; i < 4; i++)
      w[8*i +: 8] = pat(fa[24], fa[23:0] + 24'((off + i) % LB));
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // byte-stream flash: one reply per offered byte
  initial begin
    spi_rx_valid = 1'b0;
    spi_rx_byte  = 8'h00;
    forever begin
      @(negedge clk);
      if (flash_sel && !prev_sel) begin
        fills++;
        k = 0;
        bhdr = hdr_len_of(bench_cfg);
        upper_seen = 0;
        nz_data = 0;
      end
      prev_sel = flash_sel;
      if (upper_page) upper_seen = 1;
      if (spi_tx_valid) begin
        logic [7:0] resp;
        if (k < 16) hlog[k] = spi_tx_byte;
        if (k >= bhdr && spi_tx_byte != 8'h00) nz_data++;
        if (k < bhdr) resp = 8'hC3 ^ 8'(k);
        else resp = pat(upper_page, {hlog[1], hlog[2], hlog[3]} + 24'(k - bhdr));
        k++;
        tx_total = k;
        @(posedge clk); #1;
        spi_rx_valid = 1'b1;
        spi_rx_byte  = resp;
        @(posedge clk); #1;
        spi_rx_valid = 1'b0;
      end
    end
  end

  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d, output int cyc);
    @(negedge clk);
    rd_req = 1'b1;
    rd_addr = a;
    cyc = 0;
    d = '0;
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (rd_ready) break;
    end
    d = rd_data;
    rd_req = 1'b0;
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    bench_cfg = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset;
    check(rd_ready == 1'b0, "R1", "rd_ready after reset", 32'(rd_ready), 0);
    check(flash_sel == 1'b0, "R1", "flash_sel after reset", 32'(flash_sel), 0);
    check(spi_tx_valid == 1'b0, "R1", "tx_valid after reset", 32'(spi_tx_valid), 0);
  endtask

  task automatic t_first_miss;
    logic [31:0] d; int c; int f0;
    logic [7:0] eh [7];
    eh = '{8'hEB, 8'h00, 8'h00, 8'h00, 8'hA0, 8'h00, 8'h00};
    f0 = fills;
    do_read(26'h000_0010, d, c);
    check(fills == f0 + 1, "R2", "one fetch on miss", 32'(fills - f0), 1);
    check(c > LB, "R2", "miss stalled", 32'(c), LB);
    for (int i = 0; i < 7; i++)
      check(hlog[i] == eh[i], "R1", "default header byte", 32'(hlog[i]), 32'(eh[i]));
    check(tx_total == 7 + LB, "R6", "bytes per fetch", 32'(tx_total), 32'(7 + LB));
    check(nz_data == 0, "R6", "zero data-phase bytes", 32'(nz_data), 0);
    check(d == exp_word(bench_cfg, 26'h000_0010), "R6", "data after header discard",
          d, exp_word(bench_cfg, 26'h000_0010));
    check(upper_seen == 0, "R9", "lower device", 32'(upper_seen), 0);
    check(flash_sel == 1'b0, "R12", "deselect after fetch", 32'(flash_sel), 0);
  endtask

  task automatic t_hits;
    logic [31:0] d; int c; int f0;
    logic [AW-1:0] al [3];
    al = '{26'h000_0000, 26'h000_03FC, 26'h000_0101};
    f0 = fills;
    foreach (al[i]) begin
      do_read(al[i], d, c);
      check(c == 1, "R7", "hit latency", 32'(c), 1);
      check(d == exp_word(bench_cfg, al[i]), "R8", "little-endian hit word", d, exp_word(bench_cfg, al[i]));
    end
    check(fills == f0, "R7", "no fetch on hits", 32'(fills - f0), 0);
  endtask

  task automatic t_edge;
    logic [31:0] d; int c; int f0;
    f0 = fills;
    do_read(26'h000_03FE, d, c);
    check(fills == f0 + 1, "R7", "offset past limit fetches", 32'(fills - f0), 1);
    check(d == exp_word(bench_cfg, 26'h000_03FE), "R8", "wrapped word", d, exp_word(bench_cfg, 26'h000_03FE));
  endtask

  task automatic t_cfg_write;
    logic [31:0] d; int c; int f0;
    logic [7:0] eh [5];
    eh = '{8'h0B, 8'h00, 8'h00, 8'h00, 8'h00};
    write_cfg(32'h0000_010B);
    f0 = fills;
    do_read(26'h000_0010, d, c);
    check(fills == f0 + 1, "R10", "refetch after cfg write", 32'(fills - f0), 1);
    for (int i = 0; i < 5; i++)
      check(hlog[i] == eh[i], "R4", "header without mode byte", 32'(hlog[i]), 32'(eh[i]));
    check(tx_total == 5 + LB, "R5", "one filler byte", 32'(tx_total), 32'(5 + LB));
    check(d == exp_word(bench_cfg, 26'h000_0010), "R10", "data after refetch", d, exp_word(bench_cfg, 26'h000_0010));
    do_read(26'h000_0010, d, c);
    check(c == 1, "R10", "line valid again", 32'(c), 1);
  endtask

  task automatic t_upper;
    logic [31:0] d; int c;
    do_read(26'h123_4567, d, c);
    check(hlog[0] == 8'h0B, "R3", "opcode first", 32'(hlog[0]), 32'h0B);
    check(hlog[1] == 8'h23 && hlog[2] == 8'h44 && hlog[3] == 8'h00, "R3", "address MSB first",
          {8'h0, hlog[1], hlog[2], hlog[3]}, 32'h234400);
    check(upper_seen == 1, "R9", "upper device during fetch", 32'(upper_seen), 1);
    check(upper_page == 1'b0, "R9", "upper_page low after fetch", 32'(upper_page), 0);
    check(d == exp_word(bench_cfg, 26'h123_4567), "R9", "upper device data", d, exp_word(bench_cfg, 26'h123_4567));
  endtask

  task automatic t_dual;
    logic [31:0] d; int c;
    write_cfg(32'h4000_0003);
    do_read(26'h246_8820, d, c);
    check(tx_total == 4 + LB, "R4", "no mode, no filler", 32'(tx_total), 32'(4 + LB));
    check(hlog[1] == 8'h23 && hlog[2] == 8'h44 && hlog[3] == 8'h00, "R11", "halved address",
          {8'h0, hlog[1], hlog[2], hlog[3]}, 32'h234400);
    check(upper_seen == 1, "R11", "device from halved address", 32'(upper_seen), 1);
    check(d == exp_word(bench_cfg, 26'h246_8820), "R11", "parallel-bus data", d, exp_word(bench_cfg, 26'h246_8820));
  endtask

  task automatic t_cfg_mid_fill;
    int c; int f0; logic [31:0] d;
    f0 = fills;
    @(negedge clk);
    rd_req = 1'b1;
    rd_addr = 26'h080_0040;
    repeat (200) @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = 32'h0000_0003;
    bench_cfg = 32'h0000_0003;
    @(negedge clk);
    cfg_wr = 1'b0;
    c = 0;
    while (c < 6000 && !rd_ready) begin
      @(negedge clk);
      c++;
    end
    d = rd_data;
    rd_req = 1'b0;
    check(fills == f0 + 2, "R10", "overlapped fetch repeated", 32'(fills - f0), 2);
    check(hlog[1] == 8'h80, "R10", "repeat uses new config", 32'(hlog[1]), 32'h80);
    check(d == exp_word(bench_cfg, 26'h080_0040), "R10", "data from repeat", d, exp_word(bench_cfg, 26'h080_0040));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_miss();
    t_hits();
    t_edge();
    t_cfg_write();
    t_upper();
    t_dual();
    t_cfg_mid_fill();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule